// File: doc/BRIEF.md
# Interlocked Host Command Register

This block is a single 32-bit mailbox register between a host processor and an embedded security processor. The host side writes a command byte and a parameter byte. It reads back a status byte and a response byte, and both of those are filled in by the embedded side. Every field sits on a byte boundary, so the host can write any field on its own by using the byte write strobes. Only legal commands are accepted. An accepted command is latched and presented to the embedded processor together with an interrupt request. The command and its parameter are then frozen until the embedded side sends its acknowledge strobe.

The command path works like a one-deep stream toward the embedded side. `emb_irq` acts as the valid signal and `emb_ack` acts as the ready signal. The back-pressure reaches the host only through the busy flag in STATUS. No host write ever stalls: a host write made while a command is outstanding is simply dropped. The host is expected to poll STATUS until it sees the busy flag clear.

A fault controller can assert `fault_lock`. While it is asserted, all host writes are refused and the interrupt is masked. Each accepted command also sends a one-cycle restart pulse to an external watchdog.

Top module: `hcmd_reg`

## Requirements
- R1: After reset `host_rdata` is zero, `emb_irq` and `wdog_kick` are low, and `emb_cmd` and `emb_data` are zero.
- R2: Bits [31:16] of `host_rdata`, which cover the command and parameter fields, always read as zero.
- R3: Host writes to byte lanes 1 and 0 (`host_wstrb[1:0]`), which cover the status and response fields, leave `host_rdata[15:0]` unchanged.
- R4: A host write with `host_wstrb[3]` set and `host_wdata[31:24]` in 1..8, made while idle and unlocked, does four things on the next cycle: `emb_cmd` shows the code, the busy flag `host_rdata[8]` is set, the error flag `host_rdata[9]` is cleared, and `emb_irq` goes high. The codes are 1 load file, 2 query song, 3 login, 4 share song, 5 logout, 6 play song, 7 query player and 8 digital out.
- R5: A host write with `host_wstrb[2]` set, made while idle and unlocked, loads `host_wdata[23:16]` into `emb_data`. This holds whether lane 2 is written alone or together with a command.
- R6: While busy, host writes do not change `emb_cmd` or `emb_data`, and they raise no further interrupt.
- R7: An `emb_ack` pulse while busy clears the busy flag and `emb_irq` on the next cycle.
- R8: A command write with code 0 or above 8, made while idle and unlocked, leaves the block idle with no interrupt and sets the error flag `host_rdata[9]`. The flag stays set until the next accepted command.
- R9: While `fault_lock` is high, host writes have no effect and `emb_irq` is held low.
- R10: `wdog_kick` is a single-cycle pulse, one cycle after each accepted command, and it never pulses otherwise.
- R11: `emb_status_we` loads `emb_status` into `host_rdata[15:10]`, and `emb_resp_we` loads `emb_resp` into `host_rdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write access |
| host_wstrb | input | 4 | Host byte write strobes, lane 3 = command |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data: zero, zero, status, response |
| emb_irq | output | 1 | Command-pending interrupt (valid) to embedded side |
| emb_cmd | output | 8 | Latched command code |
| emb_data | output | 8 | Latched command parameter |
| emb_ack | input | 1 | Embedded acknowledge strobe (ready) |
| emb_status_we | input | 1 | Embedded status write enable |
| emb_status | input | 6 | Embedded status bits for STATUS[7:2] |
| emb_resp_we | input | 1 | Embedded response write enable |
| emb_resp | input | 8 | Embedded response byte |
| fault_lock | input | 1 | Fault controller lock |
| wdog_kick | output | 1 | Watchdog restart pulse |

## Verification
The assertions check the following on every cycle:
- the interrupt is masked under lock and is never raised without busy;
- the latched command and parameter stay frozen while busy or locked;
- an acknowledge clears busy;
- an illegal code sets the error flag without going busy;
- the watchdog pulse is single-cycle and coincides with busy.

Some behaviour can only be shown by the bench scenarios, which compare the read data against a reference model over a long mixed sequence. This covers the byte-lane isolation of the read-only fields, the zero readback of the write-only fields, the parameter write with no command, the clearing of the error flag by a later good command, and the embedded-side status and response path.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
  localparam int LANE_CMD = 3;
  localparam int LANE_DIN = 2;
  localparam int HW_FLAG_BITS = 2;

  typedef enum logic [7:0] {
    CMD_NONE         = 8'd0,
    CMD_LOAD_FILE    = 8'd1,
    CMD_QUERY_SONG   = 8'd2,
    CMD_LOGIN        = 8'd3,
    CMD_SHARE_SONG   = 8'd4,
    CMD_LOGOUT       = 8'd5,
    CMD_PLAY_SONG    = 8'd6,
    CMD_QUERY_PLAYER = 8'd7,
    CMD_DIGITAL_OUT  = 8'd8
  } hcmd_code_e;
endpackage

// File: rtl/hcmd_field.sv
module hcmd_field #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/hcmd_gate.sv
module hcmd_gate #(
  parameter int BYTE_W   = 8,
  parameter int NUM_CMDS = 8
) (
  input  logic              wr_en,
  input  logic              strb_cmd,
  input  logic              strb_din,
  input  logic [BYTE_W-1:0] code,
  input  logic              busy,
  input  logic              lock,
  output logic              cmd_wr,
  output logic              din_wr,
  output logic              code_ok
);
  localparam logic [BYTE_W-1:0] MAX_CODE = BYTE_W'(NUM_CMDS);

  logic open_win;

  always_comb begin
    open_win = wr_en && !lock && !busy;
    cmd_wr   = open_win && strb_cmd;
    din_wr   = open_win && strb_din;
    code_ok  = (code != '0) && (code <= MAX_CODE);
  end
endmodule

// File: rtl/hcmd_seq.sv
module hcmd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic code_ok,
  input  logic ack,
  input  logic lock,
  output logic accept,
  output logic busy,
  output logic err,
  output logic irq,
  output logic kick
);
  assign accept = cmd_wr && code_ok;
  assign irq    = busy && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      err  <= 1'b0;
      kick <= 1'b0;
    end else begin
      kick <= accept;
      if (accept) begin
        busy <= 1'b1;
        err  <= 1'b0;
      end else begin
        if (ack)    busy <= 1'b0;
        if (cmd_wr) err  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hcmd_reg.sv
module hcmd_reg
  import hcmd_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int NUM_CMDS = 8,
  localparam int BUS_W   = 4 * BYTE_W,
  localparam int STS_W   = BYTE_W - HW_FLAG_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [3:0]        host_wstrb,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  output logic              emb_irq,
  output logic [BYTE_W-1:0] emb_cmd,
  output logic [BYTE_W-1:0] emb_data,
  input  logic              emb_ack,
  input  logic              emb_status_we,
  input  logic [STS_W-1:0]  emb_status,
  input  logic              emb_resp_we,
  input  logic [BYTE_W-1:0] emb_resp,
  input  logic              fault_lock,
  output logic              wdog_kick
);
  localparam int CMD_LSB = LANE_CMD * BYTE_W;
  localparam int DIN_LSB = LANE_DIN * BYTE_W;

  logic              cmd_wr, din_wr, code_ok, accept, busy, err;
  logic [STS_W-1:0]  sts_hi;
  logic [BYTE_W-1:0] resp_q;

  hcmd_gate #(.BYTE_W(BYTE_W), .NUM_CMDS(NUM_CMDS)) gate_i (
    .wr_en    (host_wr_en),
    .strb_cmd (host_wstrb[LANE_CMD]),
    .strb_din (host_wstrb[LANE_DIN]),
    .code     (host_wdata[CMD_LSB +: BYTE_W]),
    .busy     (busy),
    .lock     (fault_lock),
    .cmd_wr   (cmd_wr),
    .din_wr   (din_wr),
    .code_ok  (code_ok)
  );

  hcmd_seq seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr),
    .code_ok (code_ok),
    .ack     (emb_ack),
    .lock    (fault_lock),
    .accept  (accept),
    .busy    (busy),
    .err     (err),
    .irq     (emb_irq),
    .kick    (wdog_kick)
  );

  hcmd_field #(.W(BYTE_W)) cmd_f (
    .clk(clk), .rst_n(rst_n), .we(accept),
    .d(host_wdata[CMD_LSB +: BYTE_W]), .q(emb_cmd));

  hcmd_field #(.W(BYTE_W)) din_f (
    .clk(clk), .rst_n(rst_n), .we(din_wr),
    .d(host_wdata[DIN_LSB +: BYTE_W]), .q(emb_data));

  hcmd_field #(.W(STS_W)) sts_f (
    .clk(clk), .rst_n(rst_n), .we(emb_status_we),
    .d(emb_status), .q(sts_hi));

  hcmd_field #(.W(BYTE_W)) rsp_f (
    .clk(clk), .rst_n(rst_n), .we(emb_resp_we),
    .d(emb_resp), .q(resp_q));

  assign host_rdata = {{(2*BYTE_W){1'b0}}, sts_hi, err, busy, resp_q};
endmodule

// File: rtl/hcmd_reg_chk.sv
module hcmd_reg_chk #(
  parameter int BYTE_W   = 8,
  parameter int NUM_CMDS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              strb_cmd,
  input logic [BYTE_W-1:0] code,
  input logic              rd_busy,
  input logic              rd_err,
  input logic              irq,
  input logic [BYTE_W-1:0] cmd,
  input logic [BYTE_W-1:0] din,
  input logic              ack,
  input logic              lock,
  input logic              kick
);
  localparam logic [BYTE_W-1:0] MAX_CODE = BYTE_W'(NUM_CMDS);

  logic bad_try;
  assign bad_try = wr_en && strb_cmd && !lock && !rd_busy &&
                   ((code == '0) || (code > MAX_CODE));

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !irq); // R9
  AST_IRQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_busy); // R4
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !ack) |=> ($stable(cmd) && $stable(din))); // R6
  AST_HOLD_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(cmd) && $stable(din))); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rd_busy) |=> !rd_busy); // R7
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_try |=> (rd_err && !rd_busy)); // R8
  AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick); // R10
  AST_KICK_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> rd_busy); // R10
endmodule

bind hcmd_reg hcmd_reg_chk #(.BYTE_W(BYTE_W), .NUM_CMDS(NUM_CMDS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (host_wr_en),
  .strb_cmd (host_wstrb[3]),
  .code     (host_wdata[31:24]),
  .rd_busy  (host_rdata[8]),
  .rd_err   (host_rdata[9]),
  .irq      (emb_irq),
  .cmd      (emb_cmd),
  .din      (emb_data),
  .ack      (emb_ack),
  .lock     (fault_lock),
  .kick     (wdog_kick)
);

// File: tb/hcmd_reg_tb_top.sv
`timescale 1ns/1ps
module hcmd_reg_tb_top;
  import hcmd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [3:0]  host_wstrb = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        emb_irq;
  logic [7:0]  emb_cmd, emb_data;
  logic        emb_ack = 1'b0;
  logic        emb_status_we = 1'b0;
  logic [5:0]  emb_status = '0;
  logic        emb_resp_we = 1'b0;
  logic [7:0]  emb_resp = '0;
  logic        fault_lock = 1'b0;
  logic        wdog_kick;

  always #2.5 clk = ~clk;

  hcmd_reg dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic       m_busy = 0, m_err = 0, m_kick = 0;
  logic [7:0] m_cmd = 0, m_din = 0, m_resp = 0;
  logic [5:0] m_sts = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic code_legal(logic [7:0] c);
    return (c >= 8'd1) && (c <= 8'd8);
  endfunction

  task automatic check_all();
    chk("R2 write-only fields read zero", host_rdata[31:16], 32'h0);
    chk("R4 latched command", {24'h0, emb_cmd}, {24'h0, m_cmd});
    chk("R5 latched parameter", {24'h0, emb_data}, {24'h0, m_din});
    chk("R7 busy flag", {31'h0, host_rdata[8]}, {31'h0, m_busy});
    chk("R8 error flag", {31'h0, host_rdata[9]}, {31'h0, m_err});
    chk("R9 irq", {31'h0, emb_irq}, {31'h0, m_busy && !fault_lock});
    chk("R10 kick", {31'h0, wdog_kick}, {31'h0, m_kick});
    chk("R11 status bits", {26'h0, host_rdata[15:10]}, {26'h0, m_sts});
    chk("R11 response", {24'h0, host_rdata[7:0]}, {24'h0, m_resp});
  endtask

  task automatic drive(logic we, logic [3:0] strb, logic [31:0] wd, logic ack,
                       logic swe, logic [5:0] sd, logic rwe, logic [7:0] rd,
                       logic lock);
    logic open_w, cw, acc;
    host_wr_en = we; host_wstrb = strb; host_wdata = wd; emb_ack = ack;
    emb_status_we = swe; emb_status = sd; emb_resp_we = rwe; emb_resp = rd;
    fault_lock = lock;
    open_w = we && !lock && !m_busy;
    cw  = open_w && strb[3];
    acc = cw && code_legal(wd[31:24]);
    if (open_w && strb[2]) m_din = wd[23:16];
    if (acc) begin m_cmd = wd[31:24]; m_busy = 1'b1; m_err = 1'b0; end
    else begin
      if (ack) m_busy = 1'b0;
      if (cw)  m_err  = 1'b1;
    end
    m_kick = acc;
    if (swe) m_sts = sd;
    if (rwe) m_resp = rd;
    @(negedge clk);
    check_all();
  endtask

  task automatic host_wr(logic [3:0] strb, logic [31:0] wd);
    drive(1'b1, strb, wd, 1'b0, 1'b0, 6'h0, 1'b0, 8'h0, 1'b0);
  endtask

  task automatic idle_cyc();
    drive(1'b0, 4'h0, 32'h0, 1'b0, 1'b0, 6'h0, 1'b0, 8'h0, 1'b0);
  endtask

  task automatic ack_cyc();
    drive(1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 6'h0, 1'b0, 8'h0, 1'b0);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata after reset", host_rdata, 32'h0);
    chk("R1 irq after reset", {31'h0, emb_irq}, 32'h0);
    chk("R1 kick after reset", {31'h0, wdog_kick}, 32'h0);
    chk("R1 cmd/data after reset", {16'h0, emb_cmd, emb_data}, 32'h0);
    rst_n = 1'b1;
    idle_cyc();

    // R5 parameter byte alone
    host_wr(4'b0100, 32'hAA5A_FFFF);
    chk("R5 parameter alone", {24'h0, emb_data}, 32'h5A);
    chk("R4 no command from lane 2", {31'h0, host_rdata[8]}, 32'h0);

    // R4 / R10 accepted command with parameter
    host_wr(4'b1100, {CMD_SHARE_SONG, 8'h33, 16'h0});
    chk("R4 command latched", {24'h0, emb_cmd}, 32'h4);
    chk("R4 irq raised", {31'h0, emb_irq}, 32'h1);
    chk("R10 kick pulse", {31'h0, wdog_kick}, 32'h1);
    idle_cyc();
    chk("R10 kick single", {31'h0, wdog_kick}, 32'h0);

    // R6 writes while busy
    host_wr(4'b1100, {CMD_LOGOUT, 8'h77, 16'h0});
    chk("R6 command frozen", {24'h0, emb_cmd}, 32'h4);
    chk("R6 parameter frozen", {24'h0, emb_data}, 32'h33);
    chk("R6 no new kick", {31'h0, wdog_kick}, 32'h0);

    // R3 host writes to read-only lanes
    drive(1'b0, 4'h0, 32'h0, 1'b0, 1'b1, 6'h15, 1'b1, 8'hC3, 1'b0);
    host_wr(4'b0011, 32'h0000_FFFF);
    chk("R3 read-only lanes untouched", {16'h0, host_rdata[15:0]}, {16'h0, 6'h15, 1'b0, 1'b1, 8'hC3});

    // R7 acknowledge
    ack_cyc();
    chk("R7 busy cleared", {31'h0, host_rdata[8]}, 32'h0);
    chk("R7 irq cleared", {31'h0, emb_irq}, 32'h0);

    // R8 illegal codes 0 and 9
    host_wr(4'b1000, 32'h0000_0000);
    chk("R8 code 0 sets error", {31'h0, host_rdata[9]}, 32'h1);
    host_wr(4'b1000, 32'h0900_0000);
    chk("R8 code 9 not busy", {31'h0, host_rdata[8]}, 32'h0);
    chk("R8 code 9 no irq", {31'h0, emb_irq}, 32'h0);
    host_wr(4'b1000, {CMD_DIGITAL_OUT, 24'h0});
    chk("R8 error cleared by code 8", {31'h0, host_rdata[9]}, 32'h0);
    ack_cyc();

    // R9 lock
    drive(1'b1, 4'b1100, {CMD_LOGIN, 8'h99, 16'h0}, 1'b0, 1'b0, 6'h0, 1'b0, 8'h0, 1'b1);
    chk("R9 locked write ignored", {31'h0, host_rdata[8]}, 32'h0);
    host_wr(4'b1000, {CMD_LOAD_FILE, 24'h0});
    drive(1'b0, 4'h0, 32'h0, 1'b0, 1'b0, 6'h0, 1'b0, 8'h0, 1'b1);
    chk("R9 irq masked", {31'h0, emb_irq}, 32'h0);
    idle_cyc();
    chk("R9 irq back after unlock", {31'h0, emb_irq}, 32'h1);
    ack_cyc();

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] c;
      c = 8'($urandom_range(0, 10));
      drive(($urandom_range(0, 9) < 4), 4'($urandom), {c, 8'($urandom), 16'($urandom)},
            ($urandom_range(0, 9) < 2), ($urandom_range(0, 9) < 2), 6'($urandom),
            ($urandom_range(0, 9) < 2), 8'($urandom), ($urandom_range(0, 9) < 1));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule